// File: doc/BRIEF.md
# Selectable-Rate Reference Phase Detector

This block measures how far the falling edges of an incoming timing reference sit from a locally built feedback edge train. It reports one signed error sample for each reference falling edge. Rising edges of the reference are never used. A two-bit rate code picks one of three nominal reference rates: an 8 kHz frame rate and two line rates, 1.544 MHz and 2.048 MHz. The code is captured only while reset is held. A feedback divider counts the oscillator's clock-enable steps and wraps once per nominal reference period of the captured rate.

After reset the divider waits for the first reference falling edge. It restarts on that edge, so the first sample is always zero. Each later falling edge reports the distance, in divider steps, to the nearest feedback edge. A reference that arrives after that edge gives a positive value and one that arrives before it gives a negative value. The value is saturated to the output width.

The code with both bits low is reserved. While it is captured the block raises a flag and emits no samples. If the reference stops, a sticky failure flag is set; only reset clears it. A downstream loop filter takes the error samples, and a numerically controlled oscillator supplies the step enable.

Top module: `ref_phase_det`

## Requirements
- R1: Only falling edges of `refIn` produce samples: each falling edge yields exactly one `errValid` pulse, three clock edges after the edge is sampled, and rising edges yield none.
- R2: The rate code is read with `selCode[1]` as the upper bit. Code 01 selects the frame rate with `LEN_FRAME` (default 48) steps per period. Code 10 selects the slower line rate with `LEN_LINE_A` (default 26) steps. Code 11 selects the faster line rate with `LEN_LINE_B` (default 20) steps.
- R3: When code 00 is captured, `selReserved` is 1 and `errValid` never rises. It stays that way whatever happens on `refIn`, and `refFail` stays 0.
- R4: `selCode` is captured only while `rstN` is low. Changing it with `rstN` high alters neither the divider length nor `selReserved`.
- R5: The first falling edge after reset restarts the divider at that edge and produces a sample of value 0.
- R6: For every later falling edge, let d be the divider steps since the last feedback edge. The error is +d when d is at most half the period (rounded down), and d minus the period otherwise.
- R7: The error is a two's complement value of `ERR_W` bits (default 5). It is clamped to the range -2^(ERR_W-1) to 2^(ERR_W-1)-1, which is -16..15 by default.
- R8: `errValid` is high for exactly one cycle per sample, and `errOut` holds its value between samples.
- R9: If 2×period divider steps pass with no reference falling edge, `refFail` goes to 1. It then stays 1 until `rstN` is low.
- R10: The divider and the missing-edge counter advance only in cycles where `fbEn` is 1.
- R11: While `rstN` is low, `errOut`, `errValid` and `refFail` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset; also captures `selCode` |
| refIn | input | 1 | Asynchronous reference input, falling edges used |
| selCode | input | 2 | Rate code: 01 frame rate, 10 and 11 line rates, 00 reserved |
| fbEn | input | 1 | Step enable from the oscillator; one divider step per high cycle |
| errOut | output | ERR_W | Signed, saturated phase error |
| errValid | output | 1 | One-cycle strobe marking a new `errOut` |
| selReserved | output | 1 | The captured rate code is the reserved value |
| refFail | output | 1 | Sticky flag: reference falling edge missing |

## Verification
The bench targets the rounding point at exactly half a period. At that point a comparison on the wrong side of the boundary would report -10 instead of +10 at the faster line rate. It also drives errors that go past both ends of the output range: a design that wraps instead of clamping would show -8 or +12 where -16 and +15 are expected. A rate code changed without reset must leave the period unchanged, and a design that follows the live input would saturate at the frame rate. With `fbEn` held low, a divider that counts raw clock cycles would report a nonzero error or a false reference failure. After the reference stops, the failure flag must stay set even when edges come back.

// File: rtl/rpd_pkg.sv
package rpd_pkg;

  typedef enum logic [1:0] {
    RATE_NONE   = 2'b00,
    RATE_FRAME  = 2'b01,
    RATE_LINE_A = 2'b10,
    RATE_LINE_B = 2'b11
  } rate_e;

  typedef struct packed {
    logic align;   // first falling edge after reset: restart divider
    logic sample;  // later falling edge: capture an error sample
    logic step;    // divider / watchdog advance this cycle
  } pdStrobe_t;

endpackage

// File: rtl/rpd_ctrl.sv
module rpd_ctrl
  import rpd_pkg::*;
#(
  parameter int LEN_FRAME  = 48,
  parameter int LEN_LINE_A = 26,
  parameter int LEN_LINE_B = 20,
  parameter int CNT_W      = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refIn,
  input  logic [1:0]       selCode,
  input  logic             fbEn,
  output pdStrobe_t        strobe,
  output logic [CNT_W-1:0] divLen,
  output logic             selReserved,
  output logic             refFail
);

  localparam int SYNC_LEN = 3;

  logic [SYNC_LEN-1:0] refSync;
  rate_e               rateQ;
  logic                locked;
  logic                refFall;
  logic [CNT_W-1:0]    missCnt;
  logic [CNT_W-1:0]    missLimit;
  logic                failQ;

  // two synchronizer stages plus one history stage for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) refSync <= '1;
    else       refSync <= {refSync[SYNC_LEN-2:0], refIn};
  end

  assign refFall = refSync[SYNC_LEN-1] & ~refSync[SYNC_LEN-2];

  // rate code is captured only while reset is held
  always_ff @(posedge clk) begin
    if (!rstN) rateQ <= rate_e'(selCode);
  end

  always_comb begin
    unique case (rateQ)
      RATE_FRAME:  divLen = CNT_W'(LEN_FRAME);
      RATE_LINE_A: divLen = CNT_W'(LEN_LINE_A);
      RATE_LINE_B: divLen = CNT_W'(LEN_LINE_B);
      default:     divLen = CNT_W'(LEN_LINE_B);
    endcase
  end

  assign selReserved = (rateQ == RATE_NONE);
  assign missLimit   = divLen << 1;

  always_ff @(posedge clk) begin
    if (!rstN)                       locked <= 1'b0;
    else if (refFall && !selReserved) locked <= 1'b1;
  end

  assign strobe.align  = refFall & ~locked & ~selReserved;
  assign strobe.sample = refFall &  locked & ~selReserved;
  assign strobe.step   = fbEn & ~selReserved;

  // missing-reference watchdog counted in divider steps
  always_ff @(posedge clk) begin
    if (!rstN)                                   missCnt <= '0;
    else if (selReserved)                        missCnt <= missCnt;
    else if (refFall)                            missCnt <= '0;
    else if (strobe.step && missCnt != missLimit) missCnt <= missCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                                     failQ <= 1'b0;
    else if (!selReserved && missCnt == missLimit) failQ <= 1'b1;
  end

  assign refFail = failQ;

endmodule

// File: rtl/rpd_datapath.sv
module rpd_datapath
  import rpd_pkg::*;
#(
  parameter int CNT_W = 7,
  parameter int ERR_W = 5
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  pdStrobe_t               strobe,
  input  logic [CNT_W-1:0]        divLen,
  output logic signed [ERR_W-1:0] errOut,
  output logic                    errValid
);

  typedef logic signed [CNT_W:0] wide_t;

  logic [CNT_W-1:0]        divCnt;
  logic [CNT_W-1:0]        halfLen;
  wide_t                   rawErr;
  logic signed [ERR_W-1:0] errSat;

  // feedback divider: wraps to 0 at each feedback edge
  always_ff @(posedge clk) begin
    if (!rstN)
      divCnt <= '0;
    else if (strobe.align)
      divCnt <= strobe.step ? CNT_W'(1) : '0;
    else if (strobe.step)
      divCnt <= (divCnt == divLen - 1'b1) ? '0 : divCnt + 1'b1;
  end

  assign halfLen = divLen >> 1;

  // nearest feedback edge: late reference positive, early negative
  always_comb begin
    if (divCnt <= halfLen) rawErr = wide_t'({1'b0, divCnt});
    else                   rawErr = wide_t'({1'b0, divCnt}) - wide_t'({1'b0, divLen});
  end

  generate
    if (ERR_W <= CNT_W) begin : g_clamp
      localparam wide_t ERR_HI = wide_t'((2 ** (ERR_W - 1)) - 1);
      localparam wide_t ERR_LO = wide_t'(-(2 ** (ERR_W - 1)));
      always_comb begin
        if (rawErr > ERR_HI)      errSat = ERR_HI[ERR_W-1:0];
        else if (rawErr < ERR_LO) errSat = ERR_LO[ERR_W-1:0];
        else                      errSat = rawErr[ERR_W-1:0];
      end
    end else begin : g_extend
      assign errSat = ERR_W'(rawErr);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errValid <= 1'b0;
      errOut   <= '0;
    end else begin
      errValid <= strobe.align | strobe.sample;
      if (strobe.align)       errOut <= '0;
      else if (strobe.sample) errOut <= errSat;
    end
  end

endmodule

// File: rtl/ref_phase_det.sv
module ref_phase_det
  import rpd_pkg::*;
#(
  parameter int ERR_W      = 5,
  parameter int LEN_FRAME  = 48,
  parameter int LEN_LINE_A = 26,
  parameter int LEN_LINE_B = 20
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    refIn,
  input  logic [1:0]              selCode,
  input  logic                    fbEn,
  output logic signed [ERR_W-1:0] errOut,
  output logic                    errValid,
  output logic                    selReserved,
  output logic                    refFail
);

  localparam int MAX_AB  = (LEN_LINE_A > LEN_LINE_B) ? LEN_LINE_A : LEN_LINE_B;
  localparam int MAX_LEN = (LEN_FRAME > MAX_AB) ? LEN_FRAME : MAX_AB;
  localparam int CNT_W   = $clog2(2 * MAX_LEN + 1);

  pdStrobe_t        strobe;
  logic [CNT_W-1:0] divLen;

  rpd_ctrl #(
    .LEN_FRAME (LEN_FRAME),
    .LEN_LINE_A(LEN_LINE_A),
    .LEN_LINE_B(LEN_LINE_B),
    .CNT_W     (CNT_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .refIn      (refIn),
    .selCode    (selCode),
    .fbEn       (fbEn),
    .strobe     (strobe),
    .divLen     (divLen),
    .selReserved(selReserved),
    .refFail    (refFail)
  );

  rpd_datapath #(
    .CNT_W(CNT_W),
    .ERR_W(ERR_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .divLen  (divLen),
    .errOut  (errOut),
    .errValid(errValid)
  );

endmodule

// File: rtl/ref_phase_det_chk.sv
module ref_phase_det_chk #(
  parameter int ERR_W = 5
) (
  input logic                    clk,
  input logic                    rstN,
  input logic signed [ERR_W-1:0] errOut,
  input logic                    errValid,
  input logic                    selReserved,
  input logic                    refFail
);

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    errValid |=> !errValid);

  a_r8_hold_value: assert property (@(posedge clk) disable iff (!rstN)
    !errValid |-> $stable(errOut));

  a_r3_no_sample: assert property (@(posedge clk) disable iff (!rstN)
    selReserved |-> !errValid);

  a_r3_no_fail: assert property (@(posedge clk) disable iff (!rstN)
    selReserved |-> !refFail);

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rstN)
    refFail |=> refFail);

  a_r4_code_held: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> $stable(selReserved));

endmodule

bind ref_phase_det ref_phase_det_chk #(.ERR_W(ERR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .errOut     (errOut),
  .errValid   (errValid),
  .selReserved(selReserved),
  .refFail    (refFail)
);

// File: tb/tb_ref_phase_det.sv
module tb_ref_phase_det;

  localparam int ERR_W = 5;
  localparam int NVEC  = 12;

  // rate code, reference period (cycles), expected second sample
  localparam logic [1:0] V_SEL [NVEC] = '{2'b11, 2'b11, 2'b11, 2'b11, 2'b11,
                                          2'b10, 2'b10, 2'b10,
                                          2'b01, 2'b01, 2'b01, 2'b01};
  localparam int V_PER [NVEC] = '{20, 23, 17, 30, 31, 26, 39, 24, 72, 49, 28, 46};
  localparam int V_EXP [NVEC] = '{0, 3, -3, 10, -9, 0, 13, -2, 15, 1, -16, -2};

  logic                    clk = 1'b0;
  logic                    rstN;
  logic                    refIn;
  logic [1:0]              selCode;
  logic                    fbEn;
  logic signed [ERR_W-1:0] errOut;
  logic                    errValid;
  logic                    selReserved;
  logic                    refFail;

  int testCnt = 0;
  int failCnt = 0;
  int capN    = 0;
  int capVal [8];

  always #2 clk = ~clk;

  ref_phase_det #(.ERR_W(ERR_W)) dut (
    .clk        (clk),
    .rstN       (rstN),
    .refIn      (refIn),
    .selCode    (selCode),
    .fbEn       (fbEn),
    .errOut     (errOut),
    .errValid   (errValid),
    .selReserved(selReserved),
    .refFail    (refFail)
  );

  always @(negedge clk) begin
    if (rstN && errValid) begin
      if (capN < 8) capVal[capN] = int'(errOut);
      capN = capN + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    testCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset(input logic [1:0] sel);
    rstN    = 1'b0;
    refIn   = 1'b1;
    selCode = sel;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    capN = 0;
  endtask

  task automatic runRef(input int per, input int edges);
    for (int e = 0; e < edges; e++) begin
      repeat (per / 2) @(negedge clk);
      refIn = 1'b0;
      repeat (per - per / 2) @(negedge clk);
      refIn = 1'b1;
    end
  endtask

  initial begin
    #800000;
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    fbEn    = 1'b1;
    rstN    = 1'b0;
    refIn   = 1'b1;
    selCode = 2'b11;
    repeat (3) @(negedge clk);
    // R11: outputs quiet during reset
    check("R11 errValid", int'(errValid), 0);
    check("R11 errOut", int'(errOut), 0);
    check("R11 refFail", int'(refFail), 0);

    // table walk: R1 R2 R5 R6 R7 R8
    for (int i = 0; i < NVEC; i++) begin
      doReset(V_SEL[i]);
      runRef(V_PER[i], 2);
      repeat (5) @(negedge clk);
      check("R1/R8 sample count", capN, 2);
      check("R5 first sample", capVal[0], 0);
      check("R2/R6/R7 error", capVal[1], V_EXP[i]);
      check("R9 no false fail", int'(refFail), 0);
      check("R3 flag clear", int'(selReserved), 0);
    end

    // R3: reserved code
    doReset(2'b00);
    check("R3 flag set", int'(selReserved), 1);
    runRef(20, 3);
    repeat (60) @(negedge clk);
    check("R3 no samples", capN, 0);
    check("R3 no fail", int'(refFail), 0);

    // R4: code change without reset ignored
    doReset(2'b11);
    selCode = 2'b01;
    runRef(20, 2);
    repeat (5) @(negedge clk);
    check("R4 period kept", capVal[1], 0);
    selCode = 2'b00;
    repeat (3) @(negedge clk);
    check("R4 reserved not taken", int'(selReserved), 0);

    // R10: no steps, no divider advance, no watchdog
    doReset(2'b11);
    fbEn = 1'b0;
    runRef(33, 2);
    repeat (60) @(negedge clk);
    check("R10 error frozen", capVal[1], 0);
    check("R10 no fail", int'(refFail), 0);
    fbEn = 1'b1;

    // R9: missing reference, sticky, cleared by reset
    doReset(2'b11);
    runRef(20, 2);
    repeat (20) @(negedge clk);
    check("R9 not yet", int'(refFail), 0);
    repeat (40) @(negedge clk);
    check("R9 fail set", int'(refFail), 1);
    runRef(20, 3);
    repeat (5) @(negedge clk);
    check("R9 sticky", int'(refFail), 1);
    doReset(2'b11);
    @(negedge clk);
    check("R9 reset clears", int'(refFail), 0);

    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule